// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one 8-bit byte at a time over a clocked serial link. It has no start, stop or parity bits. Software loads a byte into a transmit holding register. The byte is copied into a transmit shift register and sent one bit per transfer-clock cycle. In the same cycles, the bits arriving on the serial input are collected in a receive shift register. After the eighth bit, the received byte is placed in a receive holding register.

The transfer clock comes from one of two places:
- **Internal:** a prescaler divides the system clock by 1, 8 or 32, and an 8-bit divider value `n` then divides that result by 2(n+1). The clock is driven out on `sclk_out` only while a byte is being shifted.
- **External:** the clock arrives on `sclk_in`. It is resynchronised, and its edges step the shifter.

The block is the clock master whenever a byte is transmitted, so a byte can only be received while one is also being transmitted. In continuous-receive mode, reading the receive buffer loads the transmit buffer again, so the link keeps running without software writing a dummy byte.

The sequencer has three states:
- **IDLE** waits for a start. It moves to LEAD when transmit is enabled and the transmit buffer holds a byte.
- **LEAD** waits for the leading clock edge. On that edge it drives the next data bit and moves to TRAIL.
- **TRAIL** waits for the trailing clock edge. On that edge it samples the input bit. It then returns to LEAD, or to IDLE after the eighth bit.

Top module: `sync_serial_port`

## Requirements
- R1: A transfer carries exactly 8 bits. With `cfg_msb_first`=0, bit 0 of the byte goes out first and the first bit received lands in bit 0. With `cfg_msb_first`=1, bit 7 goes first on both lines.
- R2: With the internal clock, each half period of `sclk_out` lasts P×(`cfg_div`+1) system cycles, where P is set by `cfg_src_sel`: 0 gives P=1, 1 gives P=8, and 2 or 3 give P=32. Consecutive leading edges are therefore 2×P×(`cfg_div`+1) cycles apart.
- R3: The idle clock level is the inverse of `cfg_pol`, so `cfg_pol`=0 idles high. The leading edge is the one that leaves the idle level: on it `sdata_out` changes. The trailing edge is the one that returns to the idle level: on it `sdata_in` is sampled.
- R4: A transfer begins only when `cfg_tx_en`=1 and the transmit buffer holds a byte. `st_tx_empty` goes low when `tx_wr` is pulsed and goes high when the byte moves into the shift register.
- R5: A received byte is kept only if `cfg_rx_en`=1 when the transfer starts. Enabling reception alone, with the transmit buffer empty, produces no clock and no data.
- R6: `irq_tx` is a one-cycle pulse. With `cfg_tx_irq_on_done`=0 it fires when the byte enters the shift register. With `cfg_tx_irq_on_done`=1 it fires when the eighth bit has completed.
- R7: When a received byte moves into an empty receive buffer, `st_rx_full` rises, `rx_data` holds the byte, and `irq_rx` pulses for one cycle. A `rx_rd` pulse clears `st_rx_full`.
- R8: If `st_rx_full` is still set when the seventh bit of the next byte is sampled, `st_overrun` rises at once. That byte then raises no `irq_rx`, and `st_rx_full` stays set. `st_overrun` holds until `cfg_rx_en` is driven low.
- R9: With `cfg_cont_rx`=1 and both enables set, a `rx_rd` pulse marks the transmit buffer full again. The buffered byte is then re-sent and a new byte is received without any `tx_wr`.
- R10: With `cfg_ext_clk`=1, `sclk_in` edges step the transfer, using the same leading and trailing edge roles as R3, and `sclk_out` stays at the idle level.
- R11: After reset, `st_tx_empty`=1, `st_rx_full`=0, `st_overrun`=0, both interrupt outputs are 0, and `sclk_out` is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext_clk | input | 1 | 1 = transfer clock from `sclk_in` |
| cfg_pol | input | 1 | Clock polarity (idle level is its inverse) |
| cfg_msb_first | input | 1 | 1 = bit 7 first |
| cfg_tx_irq_on_done | input | 1 | 1 = `irq_tx` at end of shift, 0 = at buffer empty |
| cfg_cont_rx | input | 1 | Continuous-receive mode |
| cfg_src_sel | input | 2 | Prescaler select: 0 = /1, 1 = /8, 2 or 3 = /32 |
| cfg_div | input | 8 | Divider value n |
| tx_wr | input | 1 | Write pulse for the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read pulse for the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| st_tx_empty | output | 1 | Transmit buffer empty |
| st_rx_full | output | 1 | Receive buffer holds an unread byte |
| st_overrun | output | 1 | Overrun flag |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock output |
| sdata_in | input | 1 | Serial data in |
| sdata_out | output | 1 | Serial data out |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_rx | output | 1 | Receive interrupt pulse |

## Verification
The hardest case to reach is an overrun that must appear exactly on the seventh sampled bit of a second byte, while the first byte is still unread. The stimulus runs one full transfer and deliberately does not read the result. It then starts a second transfer with a slow divider, and tracks every trailing clock edge seen on `sclk_out`. The overrun flag is checked just after the sixth trailing edge, where it must still be low, and just after the seventh, where it must be high. The bench also confirms that no receive interrupt appears for that byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } ssp_state_e;

    localparam int unsigned PRESC_MAX = 32;

    function automatic int unsigned presc_ratio(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 8;
            default: return PRESC_MAX;
        endcase
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    import ssp_pkg::*;

    localparam int PRE_W = $clog2(PRESC_MAX);

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_tick;

    assign pre_tick = (pre_cnt == PRE_W'(presc_ratio(src_sel) - 1));
    assign tick     = run && pre_tick && (div_cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            div_cnt <= (div_cnt == div) ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic lead,
    output logic trail
);
    logic [SYNC_STAGES:0] pipe;
    logic                 changed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[SYNC_STAGES-1:0], pin};
    end

    assign changed = pipe[SYNC_STAGES] ^ pipe[SYNC_STAGES-1];
    assign lead    = changed && (pipe[SYNC_STAGES-1] == pol);
    assign trail   = changed && (pipe[SYNC_STAGES-1] != pol);

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_ext_clk,
    input  logic              cfg_msb_first,
    input  logic              cfg_tx_irq_on_done,
    input  logic              cfg_cont_rx,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              sdata_in,
    input  logic              int_tick,
    input  logic              ext_lead,
    input  logic              ext_trail,
    output logic              busy,
    output logic              sclk_act,
    output logic              sdata_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              st_tx_empty,
    output logic              st_rx_full,
    output logic              st_overrun,
    output logic              irq_tx,
    output logic              irq_rx
);
    import ssp_pkg::*;

    localparam int                CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0]  OVR_BIT  = CNT_W'(DATA_W - 2);

    ssp_state_e        state_q, state_d;
    logic [DATA_W-1:0] tx_buf, tx_sh, rx_sh, rx_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic              tx_full, rx_act, step, start, last;

    assign start = (state_q == ST_IDLE) && cfg_tx_en && tx_full;
    assign last  = (bit_cnt == LAST_BIT);
    assign step  = cfg_ext_clk ? ((state_q == ST_LEAD) ? ext_lead : ext_trail)
                               : int_tick;
    assign rx_next = cfg_msb_first ? {rx_sh[DATA_W-2:0], sdata_in}
                                   : {sdata_in, rx_sh[DATA_W-1:1]};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (step)  state_d = ST_TRAIL;
            ST_TRAIL: if (step)  state_d = last ? ST_IDLE : ST_LEAD;
            default:             state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf     <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            rx_data    <= '0;
            bit_cnt    <= '0;
            tx_full    <= 1'b0;
            rx_act     <= 1'b0;
            st_rx_full <= 1'b0;
            st_overrun <= 1'b0;
            sclk_act   <= 1'b0;
            sdata_out  <= 1'b1;
            irq_tx     <= 1'b0;
            irq_rx     <= 1'b0;
        end else begin
            irq_tx <= 1'b0;
            irq_rx <= 1'b0;
            if (!cfg_rx_en) st_overrun <= 1'b0;
            if (start) begin
                tx_sh   <= tx_buf;
                tx_full <= 1'b0;
                bit_cnt <= '0;
                rx_act  <= cfg_rx_en;
                irq_tx  <= !cfg_tx_irq_on_done;
            end
            if (rx_rd) begin
                st_rx_full <= 1'b0;
                if (cfg_cont_rx && cfg_rx_en && cfg_tx_en) tx_full <= 1'b1;
            end
            if (tx_wr) begin
                tx_buf  <= tx_data;
                tx_full <= 1'b1;
            end
            if (state_q == ST_LEAD && step) begin
                sdata_out <= cfg_msb_first ? tx_sh[DATA_W-1] : tx_sh[0];
                tx_sh     <= cfg_msb_first ? (tx_sh << 1) : (tx_sh >> 1);
                sclk_act  <= 1'b1;
            end
            if (state_q == ST_TRAIL && step) begin
                rx_sh    <= rx_next;
                sclk_act <= 1'b0;
                bit_cnt  <= bit_cnt + 1'b1;
                if (rx_act && st_rx_full && bit_cnt == OVR_BIT) st_overrun <= 1'b1;
                if (last) begin
                    irq_tx <= cfg_tx_irq_on_done;
                    if (rx_act) begin
                        rx_data <= rx_next;
                        if (!st_rx_full) begin
                            st_rx_full <= 1'b1;
                            irq_rx     <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign st_tx_empty = !tx_full;

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_ext_clk,
    input  logic              cfg_pol,
    input  logic              cfg_msb_first,
    input  logic              cfg_tx_irq_on_done,
    input  logic              cfg_cont_rx,
    input  logic [1:0]        cfg_src_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              st_tx_empty,
    output logic              st_rx_full,
    output logic              st_overrun,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sdata_in,
    output logic              sdata_out,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic busy, sclk_act, int_tick, ext_lead, ext_trail;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n),
        .run(busy && !cfg_ext_clk),
        .src_sel(cfg_src_sel), .div(cfg_div),
        .tick(int_tick)
    );

    ssp_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin(sclk_in), .pol(cfg_pol),
        .lead(ext_lead), .trail(ext_trail)
    );

    ssp_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_ext_clk(cfg_ext_clk), .cfg_msb_first(cfg_msb_first),
        .cfg_tx_irq_on_done(cfg_tx_irq_on_done), .cfg_cont_rx(cfg_cont_rx),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .sdata_in(sdata_in), .int_tick(int_tick),
        .ext_lead(ext_lead), .ext_trail(ext_trail),
        .busy(busy), .sclk_act(sclk_act), .sdata_out(sdata_out),
        .rx_data(rx_data), .st_tx_empty(st_tx_empty),
        .st_rx_full(st_rx_full), .st_overrun(st_overrun),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    // Idle level is the inverse of polarity; external mode keeps it idle.
    assign sclk_out = (!cfg_ext_clk && sclk_act) ? cfg_pol : !cfg_pol;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_tx_en,
    input logic cfg_rx_en,
    input logic cfg_tx_irq_on_done,
    input logic busy,
    input logic irq_tx,
    input logic irq_rx,
    input logic st_rx_full,
    input logic st_overrun
);
    assert_no_start_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_tx_en) |=> !busy);

    assert_txirq_at_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !cfg_tx_irq_on_done) |-> busy);

    assert_txirq_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && cfg_tx_irq_on_done) |-> !busy);

    assert_txirq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);

    assert_rxirq_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> st_rx_full);

    assert_overrun_no_rxirq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_overrun) |-> !irq_rx);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overrun && cfg_rx_en) |=> st_overrun);
endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
    .cfg_tx_irq_on_done(cfg_tx_irq_on_done),
    .busy(busy), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .st_rx_full(st_rx_full), .st_overrun(st_overrun)
);

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic cfg_tx_en = 0, cfg_rx_en = 0, cfg_ext_clk = 0, cfg_pol = 0;
    logic cfg_msb_first = 0, cfg_tx_irq_on_done = 0, cfg_cont_rx = 0;
    logic [1:0] cfg_src_sel = 0;
    logic [7:0] cfg_div = 0, tx_data = 0, rx_data;
    logic tx_wr = 0, rx_rd = 0, sclk_in = 1, sdata_in = 0;
    logic st_tx_empty, st_rx_full, st_overrun, sclk_out, sdata_out, irq_tx, irq_rx;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, trail_seen = 0, irq_tx_at = -1, irq_tx_cnt = 0, irq_rx_cnt = 0, tog = 0;
    logic sclk_prev = 1;

    sync_serial_port u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (irq_tx) begin irq_tx_cnt++; irq_tx_at = trail_seen; end
            if (irq_rx) irq_rx_cnt++;
            if (sclk_out !== sclk_prev) tog++;
        end
        sclk_prev = sclk_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ratio(input logic [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 8 : 32;
    endfunction

    function automatic int bit_idx(input int i, input logic msb);
        return msb ? 7 - i : i;
    endfunction

    task automatic rd_pulse();
        @(negedge clk) rx_rd = 1;
        @(negedge clk) rx_rd = 0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk) begin tx_data = b; tx_wr = 1; end
        @(negedge clk) tx_wr = 0;
    endtask

    // Internal-clock transfer; bench acts as the far-end device.
    task automatic xfer_int(input logic [7:0] txb, input logic [7:0] slvb,
                            input logic msb, input logic pol, input logic ondone,
                            input logic [1:0] sel, input logic [7:0] dv,
                            input bit chk_ovr, input int exp_rx_irq);
        logic [7:0] cap;
        int t0, t1, rx0, tx0;
        @(negedge clk);
        cfg_ext_clk = 0; cfg_msb_first = msb; cfg_pol = pol;
        cfg_tx_irq_on_done = ondone; cfg_src_sel = sel; cfg_div = dv;
        trail_seen = 0; rx0 = irq_rx_cnt; tx0 = irq_tx_cnt;
        t0 = 0; t1 = 0; cap = 0;
        wr_byte(txb);
        for (int i = 0; i < 8; i++) begin
            wait (sclk_out == pol);
            if (i == 0) t0 = cyc;
            if (i == 1) t1 = cyc;
            #1 sdata_in = slvb[bit_idx(i, msb)];
            wait (sclk_out == !pol);
            trail_seen = i + 1;
            cap[bit_idx(i, msb)] = sdata_out;
            if (chk_ovr && (i == 5 || i == 6)) begin
                repeat (2) @(negedge clk);
                check(st_overrun == (i == 6), "R8 overrun on seventh bit", st_overrun, i == 6);
            end
        end
        repeat (3) @(negedge clk);
        check(cap == txb, "R1 transmitted bit order", cap, txb);
        check(t1 - t0 == 2 * ratio(sel) * (dv + 1), "R2 clock period", t1 - t0, 2 * ratio(sel) * (dv + 1));
        check(sclk_out == !pol, "R3 idle level", sclk_out, !pol);
        check(irq_tx_cnt == tx0 + 1 && irq_tx_at == (ondone ? 8 : 0), "R6 tx irq timing",
              irq_tx_at, ondone ? 8 : 0);
        check(irq_rx_cnt == rx0 + exp_rx_irq, "R7 rx irq count", irq_rx_cnt - rx0, exp_rx_irq);
        if (exp_rx_irq == 1)
            check(st_rx_full && rx_data == slvb, "R7 received byte", rx_data, slvb);
    endtask

    // External-clock transfer; bench drives sclk_in.
    task automatic xfer_ext(input logic [7:0] txb, input logic [7:0] slvb,
                            input logic msb, input logic pol);
        logic [7:0] cap;
        bit quiet;
        quiet = 1; cap = 0;
        @(negedge clk);
        cfg_ext_clk = 1; cfg_msb_first = msb; cfg_pol = pol; sclk_in = !pol;
        repeat (6) @(negedge clk);
        wr_byte(slvb ^ slvb ^ txb);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk_in = pol; sdata_in = slvb[bit_idx(i, msb)];
            repeat (8) @(negedge clk);
            cap[bit_idx(i, msb)] = sdata_out;
            if (sclk_out != !pol) quiet = 0;
            sclk_in = !pol;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(cap == txb, "R10 ext clock transmit", cap, txb);
        check(st_rx_full && rx_data == slvb, "R10 ext clock receive", rx_data, slvb);
        check(quiet, "R10 sclk_out held idle", quiet, 1);
        rd_pulse();
        cfg_ext_clk = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t_before;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check(st_tx_empty && !st_rx_full && !st_overrun && !irq_tx && !irq_rx && sclk_out == 1,
              "R11 reset state", {st_tx_empty, st_rx_full, st_overrun, sclk_out}, 4'b1001);

        // R4: loaded buffer, transmit disabled -> nothing happens
        t_before = tog;
        wr_byte(8'hA5);
        repeat (60) @(negedge clk);
        check(!st_tx_empty && tog == t_before, "R4 no start while disabled", tog - t_before, 0);
        cfg_tx_en = 1;
        repeat (40) @(negedge clk);
        check(st_tx_empty && !st_rx_full, "R4/R5 sent without receive", {st_tx_empty, st_rx_full}, 2'b10);

        // R5: receive enabled, nothing to send -> no clock
        cfg_rx_en = 1;
        t_before = tog;
        repeat (80) @(negedge clk);
        check(tog == t_before && !st_rx_full, "R5 receive needs transmit data", tog - t_before, 0);

        // Directed transfers
        xfer_int(8'h3C, 8'hC5, 0, 0, 0, 2'd0, 8'd0, 0, 1); rd_pulse();
        xfer_int(8'h81, 8'h7E, 1, 1, 1, 2'd1, 8'd1, 0, 1); rd_pulse();
        xfer_int(8'hF0, 8'h0F, 1, 0, 1, 2'd2, 8'd0, 0, 1); rd_pulse();
        xfer_int(8'h5A, 8'h96, 0, 1, 0, 2'd3, 8'd1, 0, 1); rd_pulse();
        check(!st_rx_full, "R7 read clears full", st_rx_full, 0);

        // R5: receive disabled -> byte discarded
        cfg_rx_en = 0;
        xfer_int(8'h11, 8'hEE, 0, 0, 0, 2'd0, 8'd2, 0, 0);
        check(!st_rx_full, "R5 no capture when rx disabled", st_rx_full, 0);
        cfg_rx_en = 1;

        // Random transfers
        for (int k = 0; k < 16; k++) begin
            logic [1:0] s;
            logic [7:0] d;
            s = 2'($urandom % 3);
            d = 8'((s == 2) ? $urandom % 2 : $urandom % 6);
            xfer_int(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), s, d, 0, 1);
            rd_pulse();
        end

        // R8 overrun: two bytes, no read between
        xfer_int(8'h12, 8'h34, 0, 0, 0, 2'd0, 8'd3, 0, 1);
        xfer_int(8'h56, 8'h78, 0, 0, 0, 2'd0, 8'd3, 1, 0);
        check(st_rx_full && st_overrun, "R8 flags after overrun", {st_rx_full, st_overrun}, 2'b11);
        @(negedge clk) cfg_rx_en = 0;
        @(negedge clk) cfg_rx_en = 1;
        @(negedge clk);
        check(!st_overrun, "R8 cleared by rx disable", st_overrun, 0);
        rd_pulse();

        // R9 continuous receive
        cfg_cont_rx = 1;
        xfer_int(8'h9C, 8'h63, 1, 0, 0, 2'd0, 8'd1, 0, 1);
        t_before = irq_rx_cnt;
        rd_pulse();
        repeat (80) @(negedge clk);
        check(st_rx_full && irq_rx_cnt == t_before + 1, "R9 read re-arms reception",
              irq_rx_cnt - t_before, 1);
        cfg_cont_rx = 0;
        rd_pulse();
        repeat (5) @(negedge clk);
        check(st_tx_empty && !st_rx_full, "R9 no re-arm when mode off", {st_tx_empty, st_rx_full}, 2'b10);

        // R10 external clock
        xfer_ext(8'hB4, 8'h2D, 0, 0);
        xfer_ext(8'h6E, 8'hD1, 1, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule